// File: doc/BRIEF.md
# SPI Daisy-Chain Host Sequencer

This block is the host end of a serial link to a string of identical converter nodes wired output-to-input, so that the whole string behaves as one long shift register. On a start request it pulls chip select low and emits exactly one serial clock per bit of the chain (nodes times frame bits). It sends one command per node, with the command for the node at the far end of the string first. It collects the bits that come back and splits them into one frame per node, then releases chip select and raises a one-cycle done pulse.

Each node receives its own 16-bit command, padded with leading zeros to the frame width. A register read needs a second pass through the chain, because the register contents only come out on the following frame. When the read flag is set with start, the block runs that second pass by itself, sending all-zero frames, and returns the data from the second pass. The serial clock is a divided system clock. A static flag reports a frame width the block does not support, or more nodes than the serial clock can drain within one sample period.

Top module: `spi_chain_host`

## Requirements
- R1: Each chip-select-low window contains exactly NODES*FRAME_BITS rising serial-clock edges, and the serial clock is low whenever chip select is high.
- R2: The transmit stream is sent MSB first, with node NODES-1's frame first and node 0's frame last. Node 0 is wired to the host's data output. Node k's command is taken from cmd_i[k*16 +: 16].
- R3: Every transmitted frame holds its 16-bit command in its low 16 bits, and the FRAME_BITS-16 bits above it are zero.
- R4: Different nodes receive different commands within the same transaction, each node's frame coming only from its own slot of cmd_i.
- R5: When done_o pulses, rx_data_o[k*FRAME_BITS +: FRAME_BITS] holds node k's frame. The first FRAME_BITS bits received belong to node NODES-1.
- R6: With read_i high at start, two chip-select windows run. Chip select stays high for HALF_DIV system cycles between them. The second window transmits all zeros, and rx_data_o returns the data received in the second window.
- R7: Chip select falls HALF_DIV cycles before the first rising serial-clock edge and rises HALF_DIV cycles after the last falling edge. Each clock phase lasts HALF_DIV cycles.
- R8: busy_o is high from the cycle after an accepted start until the done pulse. done_o is a one-cycle pulse with busy_o low. A start or a change of cmd_i while busy has no effect.
- R9: cfg_err_o is high when FRAME_BITS is not 24, 32 or 40, or when NODES exceeds floor(fSCLK/(DATA_HZ*FRAME_BITS)), where fSCLK = SYS_HZ/(2*HALF_DIV).
- R10: mosi_o changes only together with a falling serial-clock edge or at chip-select fall. miso_i is sampled at each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transaction (accepted when idle) |
| read_i | input | 1 | Run the extra readback pass |
| cmd_i | input | NODES*16 | Per-node commands, node k at bits k*16 |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_data_o | output | NODES*FRAME_BITS | Received frames, node k at bits k*FRAME_BITS |
| cfg_err_o | output | 1 | Unsupported frame width or chain too long |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to node 0 |
| miso_i | input | 1 | Serial data from node NODES-1 |

## Verification
The assertions assume that the nodes shift in step with the generated clock: each node takes its input on the rising edge and moves its output on the falling edge. They also assume that start_i is a level sampled only while idle, so requests made while busy need no handshake. The stimulus applies every request between clock edges. It models the chain as one register that is loaded at chip-select fall and shifted only on serial-clock edges. It deliberately raises start_i and changes cmd_i mid-transaction to show that neither reaches the wire.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } chain_state_e;

  function automatic logic frame_ok(int unsigned bits);
    return (bits == 24) || (bits == 32) || (bits == 40);
  endfunction
endpackage

// File: rtl/spi_chain_clkgen.sv
module spi_chain_clkgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] div_q;

  assign tick_o = en_i && (div_q == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= '0;
    else if (!en_i || tick_o)  div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/spi_chain_pack.sv
module spi_chain_pack #(
  parameter int unsigned NODES      = 4,
  parameter int unsigned FRAME_BITS = 32,
  parameter int unsigned CMD_BITS   = 16
) (
  input  logic [NODES*CMD_BITS-1:0]   cmd_i,
  output logic [NODES*FRAME_BITS-1:0] img_o
);
  localparam int unsigned PAD_BITS = FRAME_BITS - CMD_BITS;

  // node k lands in slot k; top slot leaves the shifter first
  for (genvar k = 0; k < NODES; k++) begin : g_slot
    assign img_o[k*FRAME_BITS +: FRAME_BITS] = {{PAD_BITS{1'b0}}, cmd_i[k*CMD_BITS +: CMD_BITS]};
  end
endmodule

// File: rtl/spi_chain_shift.sv
module spi_chain_shift #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [WIDTH-1:0] rx_o
);
  logic [WIDTH-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_q <= '0;
    else if (load_i)  tx_q <= load_val_i;
    else if (shift_i) tx_q <= {tx_q[WIDTH-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= {rx_q[WIDTH-2:0], miso_i};
  end

  assign mosi_o = tx_q[WIDTH-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_chain_host.sv
module spi_chain_host
  import spi_chain_pkg::*;
#(
  parameter int unsigned NODES      = 4,
  parameter int unsigned FRAME_BITS = 32,
  parameter int unsigned CMD_BITS   = 16,
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned SYS_HZ     = 125_000_000,
  parameter int unsigned DATA_HZ    = 100_000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        read_i,
  input  logic [NODES*CMD_BITS-1:0]   cmd_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [NODES*FRAME_BITS-1:0] rx_data_o,
  output logic                        cfg_err_o,
  output logic                        cs_no,
  output logic                        sclk_o,
  output logic                        mosi_o,
  input  logic                        miso_i
);
  localparam int unsigned TOTAL     = NODES * FRAME_BITS;
  localparam int unsigned CNT_W     = $clog2(TOTAL + 1);
  localparam int unsigned SCLK_HZ   = SYS_HZ / (2 * HALF_DIV);
  localparam int unsigned MAX_NODES = SCLK_HZ / (DATA_HZ * FRAME_BITS);
  localparam logic        CFG_BAD   = !frame_ok(FRAME_BITS) || (NODES > MAX_NODES);

  chain_state_e     state_q;
  logic [CNT_W-1:0] bit_q;
  logic             sclk_q, cs_n_q, rd_pend_q, done_q;
  logic [TOTAL-1:0] rx_out_q, rx_w, img_w, load_val_w;
  logic             tick_w, load_w, shift_w, sample_w;

  spi_chain_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q != ST_IDLE),
    .tick_o(tick_w)
  );

  spi_chain_pack #(.NODES(NODES), .FRAME_BITS(FRAME_BITS), .CMD_BITS(CMD_BITS)) u_pack (
    .cmd_i(cmd_i),
    .img_o(img_w)
  );

  // second pass of a read carries no-op frames
  assign load_val_w = (state_q == ST_GAP) ? '0 : img_w;
  assign load_w     = ((state_q == ST_IDLE) && start_i) || ((state_q == ST_GAP) && tick_w);
  assign sample_w   = tick_w && ((state_q == ST_LEAD) || ((state_q == ST_SHIFT) && !sclk_q));
  assign shift_w    = tick_w && (state_q == ST_SHIFT) && sclk_q;

  spi_chain_shift #(.WIDTH(TOTAL)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_w),
    .load_val_i(load_val_w),
    .shift_i   (shift_w),
    .sample_i  (sample_w),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_o      (rx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      rd_pend_q <= 1'b0;
      done_q    <= 1'b0;
      rx_out_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cs_n_q    <= 1'b0;
            bit_q     <= '0;
            rd_pend_q <= read_i;
            state_q   <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick_w) begin
            sclk_q  <= 1'b1;
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick_w) begin
            if (sclk_q) begin
              sclk_q <= 1'b0;
              if (bit_q == CNT_W'(TOTAL)) state_q <= ST_TAIL;
            end else begin
              sclk_q <= 1'b1;
              bit_q  <= bit_q + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (tick_w) begin
            cs_n_q <= 1'b1;
            if (rd_pend_q) begin
              rd_pend_q <= 1'b0;
              state_q   <= ST_GAP;
            end else begin
              rx_out_q <= rx_w;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          if (tick_w) begin
            cs_n_q  <= 1'b0;
            bit_q   <= '0;
            state_q <= ST_LEAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rx_data_o = rx_out_q;
  assign cfg_err_o = CFG_BAD;
  assign cs_no     = cs_n_q;
  assign sclk_o    = sclk_q;
endmodule

// File: rtl/spi_chain_host_chk.sv
module spi_chain_host_chk #(
  parameter int unsigned NODES      = 4,
  parameter int unsigned FRAME_BITS = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o
);
  localparam int unsigned TOTAL = NODES * FRAME_BITS;
  localparam int unsigned CNT_W = $clog2(TOTAL + 2);

  logic [CNT_W-1:0] rise_q;
  logic             sclk_d, cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_o;
      cs_d   <= cs_no;
      if (!cs_no && sclk_o && !sclk_d) rise_q <= rise_q + 1'b1;
      else if (cs_no && cs_d)          rise_q <= '0;
    end
  end

  a_r1_edge_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && !cs_d) |-> (rise_q == CNT_W'(TOTAL)));

  a_r1_sclk_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);

  a_r10_mosi_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && sclk_d) |-> $stable(mosi_o));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sclk_o));
endmodule

bind spi_chain_host spi_chain_host_chk #(.NODES(NODES), .FRAME_BITS(FRAME_BITS)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .busy_o(busy_o),
  .done_o(done_o),
  .cs_no (cs_no),
  .sclk_o(sclk_o),
  .mosi_o(mosi_o)
);

// File: tb/spi_chain_host_test.sv
module spi_chain_host_test;
  localparam int unsigned NODES = 4;
  localparam int unsigned FB    = 32;
  localparam int unsigned HALF  = 2;
  localparam int unsigned TOTAL = NODES * FB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0;
  logic [NODES*16-1:0] cmd = '0;
  logic busy, done, cfg_err, cs_n, sclk, mosi, miso;
  logic [TOTAL-1:0] rx;
  logic big_busy, big_done, big_err, big_cs, big_sclk, big_mosi;
  logic [10*FB-1:0] big_rx;

  int tests = 0, fails = 0;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_chain_host #(.NODES(NODES), .FRAME_BITS(FB), .HALF_DIV(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .read_i(rd), .cmd_i(cmd),
    .busy_o(busy), .done_o(done), .rx_data_o(rx), .cfg_err_o(cfg_err),
    .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso));

  // ten nodes at 32 bits exceed the 9-node limit of a 31.25 MHz clock
  spi_chain_host #(.NODES(10), .FRAME_BITS(FB), .HALF_DIV(HALF)) uut_big (
    .clk_i(clk), .rst_ni(rst_n), .start_i(1'b0), .read_i(1'b0), .cmd_i('0),
    .busy_o(big_busy), .done_o(big_done), .rx_data_o(big_rx), .cfg_err_o(big_err),
    .cs_no(big_cs), .sclk_o(big_sclk), .mosi_o(big_mosi), .miso_i(1'b0));

  // chain model: one register, loaded at CS fall, in on rise, out on fall
  logic [TOTAL-1:0] chain = '0;
  logic cap = 1'b0;
  logic [TOTAL-1:0] load_q[$];
  logic [TOTAL-1:0] exp_cmd_q[$];
  logic [TOTAL-1:0] exp_rx_q[$];

  assign miso = chain[TOTAL-1];
  always @(negedge cs_n) chain <= (load_q.size() > 0) ? load_q.pop_front() : '0;
  always @(posedge sclk) cap <= mosi;
  always @(negedge sclk) chain <= {chain[TOTAL-2:0], cap};

  task automatic check(input string req, input logic [TOTAL-1:0] act, input logic [TOTAL-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [TOTAL-1:0] pack(input logic [NODES*16-1:0] c);
    logic [TOTAL-1:0] img = '0;
    for (int k = 0; k < NODES; k++) img[k*FB +: FB] = {{(FB-16){1'b0}}, c[k*16 +: 16]};
    return img;
  endfunction

  // monitor
  logic pcs = 1'b1, psclk = 1'b0, pbusy = 1'b0;
  int rises = 0;
  longint t_fall_cs = 0, t_rise_cs = 0, t_last_fall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pcs && !cs_n) begin
        t_fall_cs = cyc;
        rises = 0;
        if (pbusy) check("R6 gap cycles", TOTAL'(cyc - t_rise_cs), TOTAL'(HALF));
      end
      if (!psclk && sclk) begin
        rises++;
        if (rises == 1) check("R7 lead cycles", TOTAL'(cyc - t_fall_cs), TOTAL'(HALF));
      end
      if (psclk && !sclk) t_last_fall = cyc;
      if (!pcs && cs_n) begin
        t_rise_cs = cyc;
        check("R1 edge count", TOTAL'(rises), TOTAL'(TOTAL));
        check("R7 tail cycles", TOTAL'(cyc - t_last_fall), TOTAL'(HALF));
        if (exp_cmd_q.size() == 0) check("R8 extra window", '1, '0);
        else check("R2 R3 R4 R10 node commands", chain, exp_cmd_q.pop_front());
      end
      if (done) begin
        check("R8 busy low at done", TOTAL'(busy), '0);
        if (exp_rx_q.size() == 0) check("R8 extra done", '1, '0);
        else check("R5 R6 rx frames", rx, exp_rx_q.pop_front());
      end
    end
    pcs = cs_n; psclk = sclk; pbusy = busy;
  end

  task automatic run_txn(input logic [NODES*16-1:0] c, input bit r,
                         input logic [TOTAL-1:0] dev1, input logic [TOTAL-1:0] dev2);
    load_q.push_back(dev1);
    exp_cmd_q.push_back(pack(c));
    if (r) begin
      load_q.push_back(dev2);
      exp_cmd_q.push_back('0);
      exp_rx_q.push_back(dev2);
    end else begin
      exp_rx_q.push_back(dev1);
    end
    @(negedge clk);
    cmd = c; rd = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rd = 1'b0;
    check("R8 busy after start", TOTAL'(busy), 1);
    repeat (40) @(negedge clk);
    // ignored while busy
    cmd = ~c; start = 1'b1; rd = 1'b1;
    @(negedge clk);
    start = 1'b0; rd = 1'b0;
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R8 idle after done", TOTAL'({busy, cs_n, sclk}), TOTAL'(3'b010));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset outputs", TOTAL'({busy, done, cs_n, sclk}), TOTAL'(4'b0010));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 legal config", TOTAL'(cfg_err), '0);
    check("R9 chain too long", TOTAL'(big_err), 1);

    run_txn({16'h3C04, 16'hC303, 16'h5A02, 16'hA501}, 1'b0,
            {32'hDEAD0004, 32'hBEEF0003, 32'h12340002, 32'h89AB0001}, '0);
    run_txn({16'hFFFF, 16'h0000, 16'hFFFF, 16'h8001}, 1'b0,
            {4{32'hAAAA5555}}, '0);
    run_txn({16'h2011, 16'h2022, 16'h2033, 16'h2044}, 1'b1,
            {4{32'hFFFFFFFF}}, {32'h00000D04, 32'h00000C03, 32'h00000B02, 32'h00000A01});
    run_txn({16'h4100, 16'h4200, 16'h4300, 16'h4400}, 1'b1,
            {32'h80000001, 32'h7FFFFFFE, 32'h0F0F0F0F, 32'hF0F0F0F0},
            {32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210});

    repeat (50) @(negedge clk);
    check("R8 no stray transactions", TOTAL'(exp_cmd_q.size() + exp_rx_q.size() + load_q.size()), '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule